// File: doc/BRIEF.md
# Grouped Block Access Detector

This block watches a stream of block accesses and learns which blocks are always touched in a fixed succession. It keeps a table with one entry per block. Each entry holds a group identifier, a guessed predecessor block and an in-group flag. A single register holds the block that was accessed most recently.

When a block arrives and its stored predecessor guess equals the block accessed just before it, the guess is confirmed. The new block then takes the predecessor's group identifier, and both blocks are flagged as members of a group. When the guess does not match, the block records the true predecessor as its new guess, returns to a group of its own (the group identifier equals its own index) and loses its in-group flag.

Each access updates two entries, so it takes two cycles. The input is throttled with a ready signal during the second cycle. A combinational query port reads the group identifier and the in-group flag of any block at any time.

Top module: `seqgrp_tracker`

## Requirements
- R1: After reset, every entry's group identifier equals its own block index, its in-group flag is 0 and its predecessor guess is invalid, and `acc_ready` is 1.
- R2: An access is taken on a clock edge where `acc_valid` and `acc_ready` are both 1. `acc_ready` is 0 during the following cycle and is 1 again in the cycle after that. An access presented while `acc_ready` is 0 is ignored and does not change the table or the most-recent register.
- R3: The first access after reset finds no valid most-recent block and takes the mismatch path: its group identifier becomes its own index and its in-group flag is cleared.
- R4: On a mismatch, the accessed block stores the most-recent block as its guess, its group identifier is set to its own index, and its in-group flag is cleared. The previous block's entry is left unchanged.
- R5: On a match (a valid guess equal to the valid most-recent block), the accessed block copies the previous block's group identifier, and the in-group flag is set on both blocks. Repeated matches along a chain carry the first block's identifier down the chain.
- R6: After either path, the most-recent register holds the block just accessed. This includes an access to the same block twice in a row, whose second repeat can then match.
- R7: The query outputs show an entry's new value in the cycle right after the update cycle. In the update cycle they still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present |
| acc_idx | input | 5 | Index of the accessed block |
| acc_ready | output | 1 | Block can take an access this cycle |
| qry_idx | input | 5 | Block index to read out |
| qry_gid | output | 5 | Group identifier of the queried block |
| qry_ingrp | output | 1 | In-group flag of the queried block |

## Verification
The bench checks three kinds of chain behaviour. A confirmed three-block chain must carry the head's identifier to the tail; a design that copies the block's own index on a match would report the wrong group. A broken chain must clear the flag on the breaking block and leave its predecessor alone; a design that also clears the predecessor would lose it from its group. A block repeated back to back must match on its third visit, which catches a most-recent register that is not updated on the mismatch path.

The bench also holds `acc_valid` high with a new index while `acc_ready` is low. If that stale access were taken, the most-recent register would be corrupted and a later match would be missed. Further checks cover the value seen before and after the update edge, and the restore of the table by reset.

// File: rtl/seqgrp_pkg.sv
// Shared types for the grouped block access detector.
// Assumes a block count that is a power of two.
package seqgrp_pkg;
    localparam int NUM_BLK = 32;
    localparam int IDX_W   = $clog2(NUM_BLK);

    typedef logic [IDX_W-1:0] blk_idx_t;

    // One table entry: group id, predecessor guess with its valid bit, flag.
    typedef struct packed {
        blk_idx_t gid;
        logic     gvalid;
        blk_idx_t guess;
        logic     ingrp;
    } blk_ent_t;
endpackage

// File: rtl/seqgrp_meta_store.sv
// Per-block metadata table with three read ports and two write ports.
// One port writes a whole entry; the other only sets an in-group flag.
// The flag write wins over the whole-entry write on the same entry.
// Assumes the controller never asks for a flag set without an entry write.
module seqgrp_meta_store
    import seqgrp_pkg::*;
#(
    parameter int N = NUM_BLK
) (
    input  logic     clk,
    input  logic     rst_n,
    input  blk_idx_t rd_a_idx,
    output blk_ent_t rd_a,
    input  blk_idx_t rd_b_idx,
    output blk_ent_t rd_b,
    input  blk_idx_t rd_q_idx,
    output blk_ent_t rd_q,
    input  logic     wr_en,
    input  blk_idx_t wr_idx,
    input  blk_ent_t wr_data,
    input  logic     mark_en,
    input  blk_idx_t mark_idx
);
    blk_ent_t tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        blk_ent_t ent_q;

        // Hold one entry: reset to a group of its own, then apply writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '{gid: blk_idx_t'(i), gvalid: 1'b0, guess: '0, ingrp: 1'b0};
            end else begin
                if (wr_en && wr_idx == blk_idx_t'(i)) ent_q <= wr_data;
                if (mark_en && mark_idx == blk_idx_t'(i)) ent_q.ingrp <= 1'b1;
            end
        end

        assign tbl[i] = ent_q;
    end

    assign rd_a = tbl[rd_a_idx];
    assign rd_b = tbl[rd_b_idx];
    assign rd_q = tbl[rd_q_idx];

    // A flag set comes only with the update of the current entry (R5).
    p_mark_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> wr_en);
endmodule

// File: rtl/seqgrp_decide.sv
// Combinational decision for one access.
// Compares the current block's guess with the most-recent block and builds
// the new current entry and the flag-set request for the predecessor.
// Assumes both entries are read from the table in the update cycle.
module seqgrp_decide
    import seqgrp_pkg::*;
(
    input  blk_idx_t cur_idx,
    input  blk_ent_t cur_ent,
    input  blk_idx_t last_idx,
    input  logic     last_vld,
    input  blk_ent_t last_ent,
    output logic     hit,
    output blk_ent_t new_ent
);
    // Confirm the guess and form the entry that the current block gets.
    always_comb begin
        hit = last_vld && cur_ent.gvalid && (cur_ent.guess == last_idx);
        if (hit) begin
            new_ent        = cur_ent;
            new_ent.gid    = last_ent.gid;
            new_ent.ingrp  = 1'b1;
        end else begin
            new_ent.gid    = cur_idx;
            new_ent.gvalid = last_vld;
            new_ent.guess  = last_idx;
            new_ent.ingrp  = 1'b0;
        end
    end
endmodule

// File: rtl/seqgrp_ctrl.sv
// Two-phase access controller.
// It takes an access in the idle phase and updates the table in the
// following phase; ready is low during the update phase.
// It also keeps the most-recent block register.
module seqgrp_ctrl
    import seqgrp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_valid,
    input  blk_idx_t acc_idx,
    output logic     acc_ready,
    output blk_idx_t cur_idx,
    output blk_idx_t last_idx,
    output logic     last_vld,
    input  blk_ent_t cur_ent,
    input  blk_ent_t last_ent,
    input  logic     hit,
    input  blk_ent_t new_ent,
    output logic     wr_en,
    output blk_idx_t wr_idx,
    output blk_ent_t wr_data,
    output logic     mark_en,
    output blk_idx_t mark_idx
);
    typedef enum logic {ST_IDLE, ST_UPD} st_t;

    st_t      st_q;
    blk_idx_t cur_q;
    blk_idx_t last_q;
    logic     last_vld_q;

    logic take;
    logic upd;
    assign take = acc_valid && (st_q == ST_IDLE);
    assign upd  = (st_q == ST_UPD);

    // Step between the accept phase and the update phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= ST_IDLE;
        else if (take) st_q <= ST_UPD;
        else if (upd)  st_q <= ST_IDLE;
    end

    // Capture the accessed block index when an access is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur_q <= '0;
        else if (take) cur_q <= acc_idx;
    end

    // Move the most-recent block register to the current block after each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q     <= '0;
            last_vld_q <= 1'b0;
        end else if (upd) begin
            last_q     <= cur_q;
            last_vld_q <= 1'b1;
        end
    end

    // Drive the table write ports during the update phase.
    always_comb begin
        acc_ready = (st_q == ST_IDLE);
        wr_en     = upd;
        wr_idx    = cur_q;
        wr_data   = new_ent;
        mark_en   = upd && hit;
        mark_idx  = last_q;
    end

    assign cur_idx  = cur_q;
    assign last_idx = last_q;
    assign last_vld = last_vld_q;

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);
    p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |=> acc_ready);
    p_miss_own_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !hit) |=> (cur_ent.gid == $past(cur_q) && !cur_ent.ingrp));
    p_hit_joins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && hit) |=> (cur_ent.ingrp && cur_ent.gid == $past(last_ent.gid)));
    p_recent_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (last_vld && last_idx == $past(cur_q)));
endmodule

// File: rtl/seqgrp_tracker.sv
// Top level of the grouped block access detector.
// It ties the controller, the decision logic and the metadata table together.
// The query port is a combinational read of the table.
module seqgrp_tracker
    import seqgrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    output logic             acc_ready,
    input  logic [IDX_W-1:0] qry_idx,
    output logic [IDX_W-1:0] qry_gid,
    output logic             qry_ingrp
);
    blk_idx_t cur_idx, last_idx, wr_idx, mark_idx;
    blk_ent_t cur_ent, last_ent, new_ent, wr_data, q_ent;
    logic     last_vld, hit, wr_en, mark_en;

    seqgrp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_ready(acc_ready),
        .cur_idx(cur_idx), .last_idx(last_idx), .last_vld(last_vld),
        .cur_ent(cur_ent), .last_ent(last_ent),
        .hit(hit), .new_ent(new_ent),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mark_en(mark_en), .mark_idx(mark_idx)
    );

    seqgrp_decide u_decide (
        .cur_idx(cur_idx), .cur_ent(cur_ent),
        .last_idx(last_idx), .last_vld(last_vld), .last_ent(last_ent),
        .hit(hit), .new_ent(new_ent)
    );

    seqgrp_meta_store #(.N(NUM_BLK)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(cur_idx), .rd_a(cur_ent),
        .rd_b_idx(last_idx), .rd_b(last_ent),
        .rd_q_idx(qry_idx), .rd_q(q_ent),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mark_en(mark_en), .mark_idx(mark_idx)
    );

    assign qry_gid   = q_ent.gid;
    assign qry_ingrp = q_ent.ingrp;
endmodule

// File: tb/seqgrp_tracker_bench.sv
// Directed bench for the grouped block access detector.
module seqgrp_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [4:0] acc_idx = '0;
    logic       acc_ready;
    logic [4:0] qry_idx = '0;
    logic [4:0] qry_gid;
    logic       qry_ingrp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqgrp_tracker u_seqgrp_tracker (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_ready(acc_ready),
        .qry_idx(qry_idx), .qry_gid(qry_gid), .qry_ingrp(qry_ingrp)
    );

    task automatic chk_ent(input logic [4:0] idx, input logic [4:0] gid,
                           input logic ing, input string req);
        qry_idx = idx;
        #1;
        checks++;
        if (qry_gid !== gid || qry_ingrp !== ing) begin
            errors++;
            $display("FAIL %s blk %0d: gid=%0d ingrp=%0b expected gid=%0d ingrp=%0b",
                     req, idx, qry_gid, qry_ingrp, gid, ing);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Issue one access; returns at the falling edge after the update edge.
    task automatic do_access(input logic [4:0] idx);
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1;
        acc_idx   = idx;
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: whole table in reset state.
    task automatic t_reset_state();
        chk_bit(acc_ready, 1'b1, "R1 ready after reset");
        for (int i = 0; i < 32; i++) chk_ent(5'(i), 5'(i), 1'b0, "R1");
    endtask

    // R3, R4, R5, R7: pair 3 then 7, repeated.
    task automatic t_pair();
        do_access(5'd3);
        chk_ent(5'd3, 5'd3, 1'b0, "R3 first access");
        do_access(5'd7);
        chk_ent(5'd7, 5'd7, 1'b0, "R4 mismatch");
        do_access(5'd3);
        chk_ent(5'd3, 5'd3, 1'b0, "R4 mismatch again");
        // Confirming access to 7; look before and after the update edge.
        @(negedge clk);
        acc_valid = 1'b1;
        acc_idx   = 5'd7;
        @(negedge clk);
        acc_valid = 1'b0;
        chk_ent(5'd7, 5'd7, 1'b0, "R7 old value in update cycle");
        @(negedge clk);
        chk_ent(5'd7, 5'd3, 1'b1, "R5 joins predecessor group");
        chk_ent(5'd3, 5'd3, 1'b1, "R5 predecessor flagged");
        // Break: 20 after 7 leaves 7 untouched.
        do_access(5'd20);
        chk_ent(5'd20, 5'd20, 1'b0, "R4 new block");
        chk_ent(5'd7, 5'd3, 1'b1, "R4 predecessor unchanged");
    endtask

    // R5: chain 10,11,12 twice carries head id; then a break.
    task automatic t_chain();
        do_access(5'd10); do_access(5'd11); do_access(5'd12);
        do_access(5'd10); do_access(5'd11); do_access(5'd12);
        chk_ent(5'd10, 5'd10, 1'b1, "R5 chain head");
        chk_ent(5'd11, 5'd10, 1'b1, "R5 chain middle");
        chk_ent(5'd12, 5'd10, 1'b1, "R5 chain tail");
        do_access(5'd5); do_access(5'd12);
        chk_ent(5'd12, 5'd12, 1'b0, "R4 chain broken");
        chk_ent(5'd11, 5'd10, 1'b1, "R4 earlier member kept");
    endtask

    // R6: same block three times in a row.
    task automatic t_repeat();
        do_access(5'd25); do_access(5'd25);
        chk_ent(5'd25, 5'd25, 1'b0, "R6 second repeat");
        do_access(5'd25);
        chk_ent(5'd25, 5'd25, 1'b1, "R6 self match");
    endtask

    // R2: access held while ready is low must be ignored.
    task automatic t_stall();
        do_access(5'd8); do_access(5'd9);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_idx   = 5'd8;
        @(negedge clk);
        chk_bit(acc_ready, 1'b0, "R2 ready low in update");
        acc_idx = 5'd14;
        @(negedge clk);
        chk_bit(acc_ready, 1'b1, "R2 ready back");
        acc_valid = 1'b0;
        do_access(5'd9);
        chk_ent(5'd9, 5'd8, 1'b1, "R2 stale access ignored");
        chk_ent(5'd14, 5'd14, 1'b0, "R2 stalled block untouched");
    endtask

    // R1: reset restores the table after activity.
    task automatic t_rereset();
        apply_reset();
        @(negedge clk);
        chk_ent(5'd7, 5'd7, 1'b0, "R1 reset restores entry");
        chk_ent(5'd12, 5'd12, 1'b0, "R1 reset restores entry");
        do_access(5'd3); do_access(5'd7);
        chk_ent(5'd7, 5'd7, 1'b0, "R1 guess invalid after reset");
    endtask

    initial begin
        apply_reset();
        @(negedge clk);
        t_reset_state();
        t_pair();
        t_chain();
        t_repeat();
        t_stall();
        t_rereset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule